// File: doc/BRIEF.md
# Control Cycle Sequencer

This block produces the timing skeleton of a sampled control loop. Four independent timers each divide the system clock with their own prescaler. Each timer then counts from zero up to its own period and wraps. Timer 0 sets the sampling rate. Each sampling instant is marked by a single-cycle pulse, and an oversampling ratio places several evenly spaced instants inside one timer-0 period.

Every sample starts an acquisition wait of programmable length, which ends with an ADC-done pulse. A CPU postscaler picks which samples hand their data to the processor. For a picked sample, a read-phase level is held for a programmable number of cycles. The block then waits for the write-back handshake and answers it with a one-cycle data-valid pulse.

Out of reset, the block stays in a configuration phase for a fixed number of cycles. It leaves that phase with one sync pulse, and the timers start counting from zero in the same cycle. Other logic can use that pulse to clear its own counters.

Top module: `ctl_cycle_seq`

## Requirements
- R1: After reset is released, `sync_pulse` is high for exactly one cycle, in the cycle that follows the STARTUP-th rising edge (8 by default). Before that cycle, all `tick_en` bits, `tmr_count` and `sample_pulse` stay 0. The pulse never repeats until the next reset.
- R2: Each timer's `tick_en` bit is high in every cycle while its prescale field is 0 or 1. For a prescale value P > 1, the bit is high once every P cycles, and the first tick falls in the sync cycle.
- R3: Each timer count starts at 0 in the sync cycle. On each of its own ticks it advances by one, and a tick taken at a count at or above its period returns it to 0.
- R4: The four timers run independently. Timer i takes its prescale and period from bits [16i+15:16i] of the packed inputs and drives the same slice of `tmr_count`.
- R5: `sample_pulse` is combinational. It is high only in a cycle where timer 0 ticks and its count equals the current slot target. With a ratio of 1 (0 is treated as 1), this gives one pulse per timer-0 period, at count 0.
- R6: With an oversampling ratio R where R ≤ period+1, each timer-0 period holds exactly R pulses. The k-th pulse (k = 0..R-1) comes at count floor(k·(period+1)/R).
- R7: `adc_done_pulse` is high exactly L cycles after a sampling pulse, where L is `acq_latency` and 0 is treated as 1. If a new sample arrives before the pulse, the wait restarts from that sample.
- R8: With postscaler N (0 is treated as 1), the first sample after sync is picked, and then every Nth sample after it. Only picked samples open a read phase.
- R9: `reading` rises in the cycle after the ADC-done pulse of a picked sample. It stays high for `read_len` cycles, with 0 treated as 1.
- R10: Once the read phase ends, a high `write_done` sampled at a clock edge makes `data_valid_pulse` high for the single following cycle. `write_done` has no effect outside that write phase.
- R11: A picked ADC-done pulse that arrives while an earlier cycle has not yet seen its `write_done` is dropped and opens no read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_prescale | input | 64 | Packed 16-bit prescale values, timer i in bits [16i+15:16i] |
| tmr_period | input | 64 | Packed 16-bit period values, same packing |
| os_ratio | input | 4 | Sampling pulses per timer-0 period |
| acq_latency | input | 16 | Cycles from sampling pulse to ADC-done pulse |
| cpu_post | input | 8 | Samples per CPU task |
| read_len | input | 16 | Read phase length in cycles |
| write_done | input | 1 | Write-back finished handshake |
| sync_pulse | output | 1 | One-cycle end-of-configuration pulse |
| tick_en | output | 4 | Per-timer clock enable |
| tmr_count | output | 64 | Packed 16-bit timer counts |
| sample_pulse | output | 1 | Sampling instant |
| adc_done_pulse | output | 1 | Acquisition finished |
| reading | output | 1 | Read phase level |
| data_valid_pulse | output | 1 | End of write phase |

## Verification
The hardest state to reach is an overrun. A picked sample finishes acquisition while the previous cycle still waits for its write-back, and this only happens if the handshake is withheld over several sampling periods. The stimulus holds `write_done` low across five samples with a postscaler of 1. It checks that none of them opens a read phase. It then releases the handshake and confirms that the next sample after the handshake starts a new phase. A write-back strobe sent while the sequencer is idle is also checked to produce no data-valid pulse.

// File: rtl/ctl_cycle_seq.sv
module ctl_cycle_seq #(
  parameter int NTMR    = 4,
  parameter int TW      = 16,
  parameter int RW      = 4,
  parameter int PW      = 8,
  parameter int LW      = 16,
  parameter int STARTUP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTMR*TW-1:0] tmr_prescale,
  input  logic [NTMR*TW-1:0] tmr_period,
  input  logic [RW-1:0]     os_ratio,
  input  logic [LW-1:0]     acq_latency,
  input  logic [PW-1:0]     cpu_post,
  input  logic [LW-1:0]     read_len,
  input  logic              write_done,
  output logic              sync_pulse,
  output logic [NTMR-1:0]   tick_en,
  output logic [NTMR*TW-1:0] tmr_count,
  output logic              sample_pulse,
  output logic              adc_done_pulse,
  output logic              reading,
  output logic              data_valid_pulse
);
  localparam int BW = $clog2(STARTUP + 1);
  localparam int XW = TW + RW + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WAIT} phase_t;

  logic          run;
  logic [BW-1:0] boot_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      boot_cnt   <= '0;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= 1'b0;
      if (!run) begin
        boot_cnt <= boot_cnt + BW'(1);
        if (boot_cnt == BW'(STARTUP - 1)) begin
          sync_pulse <= 1'b1;
          run        <= 1'b1;
        end
      end
    end
  end

  assert_sync_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    logic [TW-1:0] pc, cnt, pre, per;
    assign pre = tmr_prescale[i*TW +: TW];
    assign per = tmr_period[i*TW +: TW];
    assign tick_en[i] = run && (pc == '0);
    assign tmr_count[i*TW +: TW] = cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc  <= '0;
        cnt <= '0;
      end else if (run) begin
        pc <= (pc + 1'b1 >= pre) ? '0 : pc + 1'b1;
        if (tick_en[i]) cnt <= (cnt >= per) ? '0 : cnt + 1'b1;
      end
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en[i] && cnt >= per) |=> cnt == '0);
  end

  logic [RW-1:0] slot, ratio;
  logic [TW-1:0] cnt0, per0;
  logic [XW-1:0] target;
  logic          wrap0;

  assign ratio  = (os_ratio == '0) ? RW'(1) : os_ratio;
  assign cnt0   = tmr_count[TW-1:0];
  assign per0   = tmr_period[TW-1:0];
  assign target = (XW'(slot) * (XW'(per0) + XW'(1))) / XW'(ratio);
  assign wrap0  = tick_en[0] && (cnt0 >= per0);
  assign sample_pulse = tick_en[0] && (target == XW'(cnt0));

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else if (wrap0) slot <= '0;
    else if (sample_pulse && slot < ratio - 1'b1) slot <= slot + 1'b1;
  end

  logic [LW-1:0] acq_cnt, lat;
  assign lat = (acq_latency == '0) ? LW'(1) : acq_latency;
  assign adc_done_pulse = (acq_cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) acq_cnt <= '0;
    else if (sample_pulse) acq_cnt <= lat;
    else if (acq_cnt != '0) acq_cnt <= acq_cnt - 1'b1;
  end

  logic [PW-1:0] post_cnt, post_n;
  logic          picked;
  assign post_n = (cpu_post == '0) ? PW'(1) : cpu_post;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_cnt <= '0;
      picked   <= 1'b0;
    end else if (sample_pulse) begin
      picked   <= (post_cnt == '0);
      post_cnt <= (post_cnt + 1'b1 >= post_n) ? '0 : post_cnt + 1'b1;
    end
  end

  phase_t        phase;
  logic [LW-1:0] rd_cnt;
  assign reading = (phase == PH_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase            <= PH_IDLE;
      rd_cnt           <= '0;
      data_valid_pulse <= 1'b0;
    end else begin
      data_valid_pulse <= 1'b0;
      case (phase)
        PH_IDLE: if (adc_done_pulse && picked) begin
          phase  <= PH_READ;
          rd_cnt <= (read_len == '0) ? LW'(1) : read_len;
        end
        PH_READ: begin
          rd_cnt <= rd_cnt - 1'b1;
          if (rd_cnt == LW'(1)) phase <= PH_WAIT;
        end
        PH_WAIT: if (write_done) begin
          phase            <= PH_IDLE;
          data_valid_pulse <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_read_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reading) |-> $past(adc_done_pulse));

  assert_valid_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_pulse |-> $past(write_done));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_pulse |=> !data_valid_pulse);
endmodule

// File: tb/ctl_cycle_seq_test.sv
module ctl_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pre_v, per_v, tmr_count;
  logic [3:0]  ratio_v, tick_en;
  logic [15:0] lat_v, rlen_v;
  logic [7:0]  post_v;
  logic        write_done = 1'b0;
  logic        sync_pulse, sample_pulse, adc_done_pulse, reading, data_valid_pulse;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctl_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .tmr_prescale(pre_v), .tmr_period(per_v),
    .os_ratio(ratio_v), .acq_latency(lat_v), .cpu_post(post_v), .read_len(rlen_v),
    .write_done(write_done), .sync_pulse(sync_pulse), .tick_en(tick_en),
    .tmr_count(tmr_count), .sample_pulse(sample_pulse), .adc_done_pulse(adc_done_pulse),
    .reading(reading), .data_valid_pulse(data_valid_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int pre0, input int per0, input int r, input int lat,
                         input int post, input int rlen);
    pre_v   = {16'd1, 16'd1, 16'd1, 16'(pre0)};
    per_v   = {16'd15, 16'd15, 16'd15, 16'(per0)};
    ratio_v = 4'(r);
    lat_v   = 16'(lat);
    post_v  = 8'(post);
    rlen_v  = 16'(rlen);
  endtask

  task automatic reset_and_sync();
    int n = 0;
    bit early = 0;
    rst_n = 1'b0;
    write_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sync_pulse && tick_en == 0 && tmr_count == 0 && !sample_pulse && !reading &&
        !data_valid_pulse && !adc_done_pulse, "R1 reset state", 1, 0);
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!sync_pulse && (tick_en != 0 || tmr_count != 0 || sample_pulse)) early = 1;
    end while (!sync_pulse && n < 100);
    chk(n == 8, "R1 sync position", n, 8);
    chk(!early, "R1 idle before sync", int'(early), 0);
  endtask

  task automatic test_timers();
    int pre[4] = '{1, 3, 0, 5};
    int per[4] = '{5, 4, 2, 0};
    int pcm[4] = '{0, 0, 0, 0};
    int cm[4]  = '{0, 0, 0, 0};
    int tick_bad[4] = '{0, 0, 0, 0};
    int cnt_bad[4]  = '{0, 0, 0, 0};
    int syncs = 0;
    set_cfg(1, 5, 1, 3, 1, 2);
    pre_v = {16'd5, 16'd0, 16'd3, 16'd1};
    per_v = {16'd0, 16'd2, 16'd4, 16'd5};
    reset_and_sync();
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (cyc > 0 && sync_pulse) syncs++;
      for (int i = 0; i < 4; i++) begin
        int pe = (pre[i] == 0) ? 1 : pre[i];
        bit et = (pcm[i] == 0);
        if (tick_en[i] != et) tick_bad[i]++;
        if (int'(tmr_count[i*16 +: 16]) != cm[i]) cnt_bad[i]++;
        if (et) cm[i] = (cm[i] >= per[i]) ? 0 : cm[i] + 1;
        pcm[i] = (pcm[i] + 1 >= pe) ? 0 : pcm[i] + 1;
      end
      @(negedge clk);
    end
    chk(syncs == 0, "R1 sync repeats", syncs, 0);
    for (int i = 0; i < 4; i++) begin
      chk(tick_bad[i] == 0, $sformatf("R2 timer%0d tick mismatches", i), tick_bad[i], 0);
      chk(cnt_bad[i] == 0, $sformatf("R3 R4 timer%0d count mismatches", i), cnt_bad[i], 0);
    end
  endtask

  task automatic test_sampling(input int pre, input int per, input int r, input int periods,
                               input string req);
    int pe = (pre == 0) ? 1 : pre;
    int re = (r == 0) ? 1 : r;
    int total = pe * (per + 1) * periods;
    int k = 0, bad = 0, bad_act = 0, bad_exp = 0;
    set_cfg(pre, per, r, 2, 1, 1);
    reset_and_sync();
    write_done = 1'b1;
    for (int cyc = 0; cyc < total; cyc++) begin
      if (sample_pulse) begin
        int ex = ((k % re) * (per + 1)) / re;
        if (int'(tmr_count[15:0]) != ex && bad == 0) begin
          bad = 1; bad_act = int'(tmr_count[15:0]); bad_exp = ex;
        end
        k++;
      end
      @(negedge clk);
    end
    write_done = 1'b0;
    chk(k == periods * re, {req, " pulse count"}, k, periods * re);
    chk(bad == 0, {req, " pulse position"}, bad_act, bad_exp);
  endtask

  task automatic test_adc(input int per, input int lat, input int ncyc, input int exp_n,
                          input int gap);
    int last = -1000, n = 0, badgap = 0, bad_val = 0;
    set_cfg(1, per, 1, lat, 1, 1);
    reset_and_sync();
    write_done = 1'b1;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      if (adc_done_pulse) begin
        n++;
        if (cyc - last != gap && badgap == 0) begin badgap = 1; bad_val = cyc - last; end
      end
      if (sample_pulse) last = cyc;
      @(negedge clk);
    end
    write_done = 1'b0;
    chk(n == exp_n, "R7 done count", n, exp_n);
    chk(badgap == 0, "R7 done latency", bad_val, gap);
  endtask

  task automatic test_post();
    int rises = 0, dvs = 0, wd_at = -1, rd_start = 0, last_done = -10;
    bit prev_rd = 0;
    set_cfg(1, 19, 1, 2, 3, 4);
    reset_and_sync();
    for (int cyc = 0; cyc < 120; cyc++) begin
      if (adc_done_pulse) last_done = cyc;
      if (reading && !prev_rd) begin
        rises++;
        rd_start = cyc;
        chk(cyc == ((rises == 1) ? 3 : 63), "R8 picked sample", cyc, (rises == 1) ? 3 : 63);
        chk(cyc == last_done + 1, "R9 read start", cyc, last_done + 1);
      end
      if (!reading && prev_rd) begin
        chk(cyc - rd_start == 4, "R9 read length", cyc - rd_start, 4);
        wd_at = cyc + 2;
      end
      if (data_valid_pulse) begin
        dvs++;
        chk(cyc == wd_at + 1, "R10 valid timing", cyc, wd_at + 1);
      end
      prev_rd = reading;
      write_done = (cyc == wd_at) || (cyc == 30);
      @(negedge clk);
    end
    write_done = 1'b0;
    chk(rises == 2, "R8 read phases", rises, 2);
    chk(dvs == 2, "R10 valid pulses", dvs, 2);
  endtask

  task automatic test_overrun();
    int rises = 0, second = -1, dvs = 0, dv_at = -1;
    bit prev_rd = 0;
    set_cfg(1, 9, 1, 2, 1, 3);
    reset_and_sync();
    for (int cyc = 0; cyc < 75; cyc++) begin
      if (reading && !prev_rd) begin
        rises++;
        if (rises == 2) second = cyc;
      end
      if (data_valid_pulse) begin dvs++; dv_at = cyc; end
      prev_rd = reading;
      write_done = (cyc == 60);
      @(negedge clk);
    end
    write_done = 1'b0;
    chk(rises == 2, "R11 dropped overrun reads", rises, 2);
    chk(second == 63, "R11 resume after ack", second, 63);
    chk(dvs == 1 && dv_at == 61, "R10 valid after held ack", dv_at, 61);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 9, 1, 1, 1, 1);
    test_timers();
    test_sampling(1, 9, 1, 2, "R5");
    test_sampling(3, 5, 0, 2, "R5");
    test_sampling(1, 9, 3, 3, "R6");
    test_sampling(2, 7, 4, 3, "R6");
    test_sampling(1, 3, 4, 2, "R6");
    test_adc(49, 5, 100, 2, 5);
    test_adc(9, 0, 20, 2, 1);
    test_adc(3, 6, 40, 0, 6);
    test_post();
    test_overrun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule